// File: doc/BRIEF.md
# Slow peripheral register bus controller

This block sits between a bus-side state machine and a slow, byte-wide peripheral controller chip. It accepts one read or write request at a time, with an address and write data, and turns it into the strobe sequence that the chip expects. An active-low select frames the access. A chip-enable line gives the direction: high for a read, low for a write. A write also asserts an active-low write enable. The write data goes out on a data bus with an output-enable, so that a pad ring can build the tri-state driver. The controller then waits for the chip's active-low ready. When ready arrives it reports completion with a one-cycle done pulse and, for a read, the data it sampled. The strobes then stay asserted for a short fixed window so that the chip can close its cycle cleanly.

The block also makes the peripheral's housekeeping signals:
- a clock at one eighth of the bus clock;
- an active-low reset pulse after system reset;
- a static output that marks the card as system controller or ordinary device;
- a registered copy of the chip's active-low interrupt, passed upstream.

A programmable timeout ends any access whose ready never comes. Such an access finishes with an error flag and all-ones read data. Only single transfers are supported.

Top module: `perbus_ctrl`

## Requirements
- R1: After reset, `per_clk` is low. It then toggles every `CLK_DIV/2` bus clocks, giving a period of `CLK_DIV` cycles (8 by default) at 50 % duty.
- R2: `per_rst_n` is low while `rst_n` is low. After internal reset release it stays low for `RST_CYCLES` more cycles. No request is accepted while it is low.
- R3: `per_sc` always equals the parameter `IS_SYS_CTRL` (1 = system controller, 0 = ordinary device).
- R4: A request seen in the idle state starts an access on the next cycle. `per_sel_n` goes low and `per_addr` takes the request address. For a write, `per_ce` = 0, `per_we_n` = 0, `per_data_oe` = 1 and `per_data_o` = write data. For a read, `per_ce` = 1, `per_we_n` = 1 and `per_data_oe` = 0, so the bus is left at high impedance.
- R5: The access stays open until a clock edge samples `per_ready_n` low. `rsp_done` is high for exactly the one cycle after that edge.
- R6: On a read, `rsp_rdata` takes `per_data_i` from the edge on which ready is sampled low. It holds that value until the next completion. Data present while ready is high is never captured.
- R7: All strobes, the address and the write data stay asserted for `HOLD_CYC` cycles starting with the done cycle. After that the select, enable and write-enable lines return high and `per_data_oe` returns low.
- R8: The access may last at most `tmo_limit`+1 cycles. If ready is still high on the last of them, the access completes with `rsp_err` = 1 and `rsp_rdata` = all ones. Ready sampled low on that last cycle still counts as success.
- R9: A request raised while an access is open, or during the peripheral reset pulse, is ignored. It does not change the address and starts no later access.
- R10: `irq_n` equals `per_irq_n` delayed by one bus clock.
- R11: A successful completion clears `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, sampled in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Peripheral register address |
| req_wdata | input | DATA_W | Write data |
| tmo_limit | input | TMO_W | Timeout: access may last tmo_limit+1 cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Last access timed out |
| rsp_rdata | output | DATA_W | Read data (all ones on timeout) |
| irq_n | output | 1 | Registered peripheral interrupt, active low |
| per_clk | output | 1 | Peripheral clock, bus clock / CLK_DIV |
| per_rst_n | output | 1 | Peripheral reset pulse, active low |
| per_sel_n | output | 1 | Access select, active low |
| per_ce | output | 1 | Direction enable: high read, low write |
| per_we_n | output | 1 | Write enable, active low |
| per_sc | output | 1 | System-controller select |
| per_addr | output | ADDR_W | Peripheral address bus |
| per_data_o | output | DATA_W | Data bus out value |
| per_data_oe | output | 1 | Data bus output enable (low = high impedance) |
| per_data_i | input | DATA_W | Data bus in value |
| per_ready_n | input | 1 | Peripheral ready, active low |
| per_irq_n | input | 1 | Peripheral interrupt, active low |

## Verification
The bench sweeps every address in both directions with ready arriving zero to three cycles into the access. It then sweeps every small timeout limit with ready arriving just inside, exactly at, and just past the limit. An off-by-one in the timeout compare shows up as an error flag on the boundary access, or as a missing one. Garbage is driven on the input data bus whenever ready is high, so a design that samples data one cycle early or late returns the wrong byte. A request is also raised in the middle of an access and during the peripheral reset pulse. A design that accepts either one moves the address or starts an extra access. Short or mis-aligned hold windows, a wrong clock ratio and a stuck error flag after a timeout are each caught at the ports.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  typedef enum logic [1:0] {
    PB_RESET  = 2'd0,
    PB_IDLE   = 2'd1,
    PB_ACCESS = 2'd2,
    PB_HOLD   = 2'd3
  } pb_state_e;
endpackage

// File: rtl/pbc_rstsync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module pbc_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pbc_clkdiv.sv
// Even divider producing a 50 % duty peripheral clock.
module pbc_clkdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_out
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
    out_d = wrap ? ~out_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/pbc_seq.sv
// Access sequencer: reset pulse, request latch, ready wait with timeout,
// fixed hold window. One shared counter serves all three timed phases.
module pbc_seq
  import pbc_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int TMO_W      = 4,
  parameter int RST_CYCLES = 4,
  parameter int HOLD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              per_ready_n,
  input  logic [DATA_W-1:0] per_data_i,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              per_rst_n,
  output logic              per_sel_n,
  output logic              per_ce,
  output logic              per_we_n,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_data_o,
  output logic              per_data_oe
);
  localparam int RW    = $clog2(RST_CYCLES + 1);
  localparam int HW    = $clog2(HOLD_CYC + 1);
  localparam int RH    = (RW > HW) ? RW : HW;
  localparam int CNT_W = (TMO_W > RH) ? TMO_W : RH;

  pb_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              ld_req, fin, fin_err;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              active;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    ld_req  = 1'b0;
    fin     = 1'b0;
    fin_err = 1'b0;
    case (state_q)
      PB_RESET: begin
        if (cnt_q == CNT_W'(RST_CYCLES - 1)) begin
          state_d = PB_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PB_IDLE: begin
        if (req_valid) begin
          state_d = PB_ACCESS;
          cnt_d   = '0;
          ld_req  = 1'b1;
        end
      end
      PB_ACCESS: begin
        if (!per_ready_n) begin
          state_d = PB_HOLD;
          cnt_d   = '0;
          done_d  = 1'b1;
          fin     = 1'b1;
        end else if (cnt_q == CNT_W'(tmo_limit)) begin
          state_d = PB_HOLD;
          cnt_d   = '0;
          done_d  = 1'b1;
          fin     = 1'b1;
          fin_err = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PB_HOLD: begin
        if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
          state_d = PB_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = PB_RESET;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PB_RESET;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (ld_req) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (fin) begin
      err_q <= fin_err;
      if (fin_err)    rdata_q <= '1;
      else if (!wr_q) rdata_q <= per_data_i;
    end
  end

  assign active      = (state_q == PB_ACCESS) || (state_q == PB_HOLD);
  assign per_rst_n   = (state_q != PB_RESET);
  assign per_sel_n   = ~active;
  assign per_ce      = ~(active & wr_q);
  assign per_we_n    = ~(active & wr_q);
  assign per_data_oe = active & wr_q;
  assign per_addr    = addr_q;
  assign per_data_o  = wdata_q;
  assign rsp_done    = done_q;
  assign rsp_err     = err_q;
  assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/perbus_ctrl.sv
module perbus_ctrl #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 4,
  parameter int CLK_DIV     = 8,
  parameter int RST_CYCLES  = 4,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit IS_SYS_CTRL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_n,
  output logic              per_clk,
  output logic              per_rst_n,
  output logic              per_sel_n,
  output logic              per_ce,
  output logic              per_we_n,
  output logic              per_sc,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_data_o,
  output logic              per_data_oe,
  input  logic [DATA_W-1:0] per_data_i,
  input  logic              per_ready_n,
  input  logic              per_irq_n
);
  logic rst_n_int;
  logic irq_q;

  pbc_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pbc_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clk_out (per_clk)
  );

  pbc_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TMO_W      (TMO_W),
    .RST_CYCLES (RST_CYCLES),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .tmo_limit   (tmo_limit),
    .per_ready_n (per_ready_n),
    .per_data_i  (per_data_i),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .per_rst_n   (per_rst_n),
    .per_sel_n   (per_sel_n),
    .per_ce      (per_ce),
    .per_we_n    (per_we_n),
    .per_addr    (per_addr),
    .per_data_o  (per_data_o),
    .per_data_oe (per_data_oe)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) irq_q <= 1'b1;
    else            irq_q <= per_irq_n;
  end

  assign irq_n  = irq_q;
  assign per_sc = IS_SYS_CTRL;
endmodule

// File: rtl/perbus_ctrl_chk.sv
module perbus_ctrl_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              per_rst_n,
  input logic              per_sel_n,
  input logic              per_ce,
  input logic              per_we_n,
  input logic [ADDR_W-1:0] per_addr,
  input logic              per_data_oe,
  input logic              per_ready_n,
  input logic              per_irq_n,
  input logic              irq_n
);
  AST_WE_NEEDS_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !per_we_n |-> (!per_ce && !per_sel_n)); // R4
  AST_READ_BUS_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_sel_n && per_ce) |-> !per_data_oe); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R5
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_err) |-> $past(!per_ready_n)); // R5
  AST_STROBES_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !per_sel_n); // R7
  AST_ACCESS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_sel_n && $past(!per_sel_n)) |-> ($stable(per_addr) && $stable(per_ce))); // R7
  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_rdata == '1)); // R8
  AST_TIMEOUT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> $past(per_ready_n)); // R8
  AST_QUIET_IN_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !per_rst_n |-> per_sel_n); // R2
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (per_rst_n && $past(per_rst_n)) |-> (irq_n == $past(per_irq_n))); // R10
endmodule

bind perbus_ctrl perbus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rsp_done    (rsp_done),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .per_rst_n   (per_rst_n),
  .per_sel_n   (per_sel_n),
  .per_ce      (per_ce),
  .per_we_n    (per_we_n),
  .per_addr    (per_addr),
  .per_data_oe (per_data_oe),
  .per_ready_n (per_ready_n),
  .per_irq_n   (per_irq_n),
  .irq_n       (irq_n)
);

// File: tb/perbus_ctrl_test.sv
`timescale 1ns/1ps
module perbus_ctrl_test;
  localparam int AW   = 3;
  localparam int DW   = 8;
  localparam int TW   = 4;
  localparam int DIV  = 8;
  localparam int RSTC = 4;
  localparam int HOLD = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [TW-1:0] tmo_limit;
  logic          rsp_done, rsp_err, irq_n;
  logic [DW-1:0] rsp_rdata;
  logic          per_clk, per_rst_n, per_sel_n, per_ce, per_we_n, per_sc;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_data_o, per_data_i;
  logic          per_data_oe, per_ready_n, per_irq_n;

  int n_cmp = 0;
  int n_bad = 0;

  perbus_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .TMO_W(TW), .CLK_DIV(DIV),
    .RST_CYCLES(RSTC), .HOLD_CYC(HOLD), .SYNC_STAGES(2), .IS_SYS_CTRL(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .tmo_limit(tmo_limit),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .irq_n(irq_n),
    .per_clk(per_clk), .per_rst_n(per_rst_n), .per_sel_n(per_sel_n),
    .per_ce(per_ce), .per_we_n(per_we_n), .per_sc(per_sc), .per_addr(per_addr),
    .per_data_o(per_data_o), .per_data_oe(per_data_oe), .per_data_i(per_data_i),
    .per_ready_n(per_ready_n), .per_irq_n(per_irq_n)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check_active(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    check("R4 sel_n", per_sel_n, 0);
    check("R4 addr", per_addr, a);
    check("R4 ce", per_ce, !wr);
    check("R4 we_n", per_we_n, !wr);
    check("R4 data_oe", per_data_oe, wr);
    if (wr) check("R4 data_o", per_data_o, wd);
  endtask

  task automatic check_released();
    check("R7 sel_n released", per_sel_n, 1);
    check("R7 ce released", per_ce, 1);
    check("R7 we_n released", per_we_n, 1);
    check("R7 data_oe released", per_data_oe, 0);
  endtask

  // One access; ready low during access cycle d; stray = request raised mid-access
  task automatic run_xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input int d, input int lim, input logic [DW-1:0] rv, input bit stray);
    bit exp_err;
    bit fin;
    int i;
    exp_err = (d > lim);
    fin = 0;
    i = 0;
    @(negedge clk);
    tmo_limit = TW'(lim); req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!fin) begin
      check_active(wr, a, wd);
      check("R5 no done before ready", rsp_done, 0);
      if (stray && i == 0) begin
        req_valid = 1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
      end
      if (i == d) begin per_ready_n = 0; per_data_i = rv; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      per_ready_n = 1; per_data_i = rv ^ 8'hA5;
      if ((!exp_err && i == d) || (exp_err && i == lim)) fin = 1;
      else i++;
    end
    check("R5 done pulse", rsp_done, 1);
    check("R8 R11 err flag", rsp_err, exp_err);
    if (exp_err) check("R8 all-ones data", rsp_rdata, {DW{1'b1}});
    else if (!wr) check("R6 read data", rsp_rdata, rv);
    check_active(wr, a, wd);
    if (stray) check("R9 stray ignored addr", per_addr, a);
    for (int h = 1; h < HOLD; h++) begin
      @(posedge clk); @(negedge clk);
      check("R5 done one cycle", rsp_done, 0);
      check_active(wr, a, wd);
      if (!exp_err && !wr) check("R6 data held", rsp_rdata, rv);
    end
    @(posedge clk); @(negedge clk);
    check_released();
    if (stray) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); @(negedge clk);
        check("R9 no second access", per_sel_n, 1);
        check("R9 no second done", rsp_done, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic s [0:79];
    int low_cnt;
    int k0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    tmo_limit = 4'd15; per_data_i = '0; per_ready_n = 1; per_irq_n = 1;
    repeat (3) @(negedge clk);
    check("R2 per_rst_n in reset", per_rst_n, 0);
    check("R1 per_clk low in reset", per_clk, 0);
    check("R5 done low in reset", rsp_done, 0);
    check("R7 sel_n high in reset", per_sel_n, 1);
    check("R3 sc", per_sc, 1);
    // release with a request held: it must be ignored during the reset pulse
    rst_n = 1; req_valid = 1; req_write = 1; req_addr = 3'd5;
    low_cnt = 0;
    while (per_rst_n == 0 && low_cnt < 40) begin
      check("R2 no access during pulse", per_sel_n, 1);
      @(posedge clk); @(negedge clk);
      if (per_rst_n == 0) low_cnt++;
    end
    req_valid = 0;
    check("R2 pulse length", (low_cnt >= RSTC && low_cnt <= RSTC + 3), 1);
    @(posedge clk); @(negedge clk);
    check("R2 request ignored", per_sel_n, 1);
    check("R3 sc", per_sc, 1);

    // R1: clock ratio and duty
    for (int j = 0; j < 80; j++) begin s[j] = per_clk; @(posedge clk); @(negedge clk); end
    k0 = -1;
    for (int j = 1; j < 20; j++) if (k0 < 0 && s[j] && !s[j-1]) k0 = j;
    check("R1 rising edge found", (k0 > 0), 1);
    if (k0 > 0)
      for (int j = 0; j < 48; j++) check("R1 per_clk shape", s[k0+j], ((j % DIV) < DIV/2));

    // R10: interrupt passthrough
    @(negedge clk); per_irq_n = 0;
    check("R10 irq not yet", irq_n, 1);
    @(posedge clk); @(negedge clk);
    check("R10 irq follows", irq_n, 0);
    per_irq_n = 1;
    @(posedge clk); @(negedge clk);
    check("R10 irq released", irq_n, 1);

    // sweep: all addresses, both directions, ready delays 0..3
    for (int a = 0; a < (1 << AW); a++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 4; d++)
          run_xfer(w[0], AW'(a), DW'(a * 37 + d * 11 + w * 5 + 3), d, 15,
                   DW'(a * 29 + d * 7 + 8'h40), 1'b0);

    // timeout boundaries: ready just inside, at, and past the limit
    for (int lim = 0; lim < 4; lim++)
      for (int d = 0; d <= lim + 1; d++)
        for (int w = 0; w < 2; w++)
          run_xfer(w[0], AW'(lim + d), DW'(lim * 17 + d), d, lim,
                   DW'(8'h10 + lim * 4 + d), 1'b0);

    // R11: timeout then success clears the flag
    run_xfer(1'b0, 3'd2, 8'h00, 3, 1, 8'h77, 1'b0);
    run_xfer(1'b0, 3'd2, 8'h00, 1, 1, 8'h3C, 1'b0);

    // R9: stray requests mid-access
    run_xfer(1'b0, 3'd1, 8'h00, 2, 15, 8'hC3, 1'b1);
    run_xfer(1'b1, 3'd6, 8'h9E, 0, 15, 8'h00, 1'b1);
    check("R3 sc end", per_sc, 1);

    summary();
  end
endmodule